// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter units, each with a 16-bit count split into a low and a high byte. Every unit advances once per machine cycle, or, when set to count events, once for each falling edge seen on its own event pin. The machine-cycle strobe `tick_i` marks each machine cycle. An optional gate lets a unit run only while its gate pin is high, which allows pulse widths to be measured.

Each unit takes one of four count layouts:
- a 13-bit counter made from a 5-bit low field and the high byte;
- a full 16-bit counter;
- an 8-bit low counter that reloads from the high byte;
- a split layout. When unit 0 is split, it becomes two 8-bit counters, and its high byte takes over unit 1's run bit and overflow flag while unit 1 freezes. A unit 1 set to the split layout simply holds its count.

Software reaches the registers through a byte-wide register bus. Writes happen on the clock edge and reads are combinational. The two overflow flags are brought out as outputs.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset, all six registers read 0x00 and both overflow flags are low.
- R2: The register addresses are 0 = mode, 1 = control, 2 = unit 0 low byte, 3 = unit 0 high byte, 4 = unit 1 low byte, 5 = unit 1 high byte. The mode register reads back what was written. The control register holds run0 at bit 4, flag0 at bit 5, run1 at bit 6 and flag1 at bit 7, and its bits 3:0 read 0. Unit 0 uses mode bits 3:0 and unit 1 uses mode bits 7:4. Within a nibble, bit 3 is the gate, bit 2 selects event counting when 1, and bits 1:0 pick the layout (0 = 13-bit, 1 = 16-bit, 2 = 8-bit reload, 3 = split/hold).
- R3: A unit counts once in each cycle with `tick_i` high, provided its run bit is 1 and either its gate bit is 0 or its gate pin is high. Otherwise it does not count. Writing the run bit leaves the count unchanged.
- R4: With event counting selected, the unit samples its event pin in each tick cycle. It counts one when that sample is 0 and the previous tick's sample was 1. Pin changes between ticks add nothing.
- R5: In layout 0, the high byte and the low 5 bits of the low byte form a 13-bit counter. Bits 7:5 of the low byte stay unchanged. Rolling over from 0x1FFF to 0 sets the unit's flag.
- R6: In layout 1, the two bytes form a 16-bit counter. Rolling over from 0xFFFF to 0 sets the flag.
- R7: In layout 2, the low byte counts. When it overflows from 0xFF, it takes the high byte's value and sets the flag, and the high byte never changes.
- R8: Unit 1 in layout 3 holds its count even while its run bit is 1.
- R9: With unit 0 in layout 3, its low byte is an 8-bit counter that uses unit 0's controls and flag0. Its high byte counts ticks under run1 alone, ignoring gate and event select, and rolling over sets flag1. Unit 1 holds its count.
- R10: A flag stays set until software writes the control register. A hardware set in the same cycle as a software clear wins.
- R11: A bus write to a count byte takes effect in place of any increment in that cycle. The unit does not count in that cycle; in the split layout only the written byte is affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Machine-cycle strobe |
| evt_pin_i | input | 2 | Event pins, one per unit |
| gate_pin_i | input | 2 | Gate pins, one per unit |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| ovf_o | output | 2 | Overflow flags, bit 0 for unit 0 and bit 1 for unit 1 |

## Verification
Every count update and every flag set lands on the clock edge that ends the tick cycle, so it is visible one edge after the stimulus. Register writes likewise show on the next edge, and reads are combinational. The bench drives `tick_i`, the pins and the bus just after a falling edge, and holds them for exactly the number of edges it intends. It then reads the count bytes and `ovf_o` one falling edge later, before any new stimulus, so each expected value corresponds to a known count of rising edges. The same-cycle collisions (write against increment, clear against overflow) are forced by raising `tick_i` and `wr_i` in the same cycle.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;

   typedef enum logic [1:0] {
      LAY_13  = 2'd0,
      LAY_16  = 2'd1,
      LAY_RLD = 2'd2,
      LAY_SPL = 2'd3
   } tmr_layout_e;

   localparam int REG_AW = 3;

   localparam logic [REG_AW-1:0] RA_MODE = 3'd0;
   localparam logic [REG_AW-1:0] RA_CTRL = 3'd1;
   localparam logic [REG_AW-1:0] RA_U0LO = 3'd2;
   localparam logic [REG_AW-1:0] RA_U0HI = 3'd3;
   localparam logic [REG_AW-1:0] RA_U1LO = 3'd4;
   localparam logic [REG_AW-1:0] RA_U1HI = 3'd5;

   localparam int NIB_GATE = 3;
   localparam int NIB_EVT  = 2;

   localparam int CB_RUN0  = 4;
   localparam int CB_FLG0  = 5;
   localparam int CB_RUN1  = 6;
   localparam int CB_FLG1  = 7;

endpackage

// File: rtl/dt_pin_edge.sv
module dt_pin_edge (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic smp_i,
   input  logic pin_i,
   output logic fall_o
);

   logic prev_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
      end else if (smp_i) begin
         prev_q <= pin_i;
      end
   end

   assign fall_o = smp_i & prev_q & ~pin_i;

endmodule

// File: rtl/dt_count_core.sv
module dt_count_core
   import dual_timer_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int PRE_W  = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  tmr_layout_e       lay_i,
   input  logic              split_i,
   input  logic              hold_i,
   input  logic              cnt_en_i,
   input  logic              hi_en_i,
   input  logic              wr_lo_i,
   input  logic              wr_hi_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] lo_o,
   output logic [BYTE_W-1:0] hi_o,
   output logic              ovf_o,
   output logic              hi_ovf_o
);

   localparam int M13_W = BYTE_W + PRE_W;
   localparam int M16_W = 2 * BYTE_W;

   logic [BYTE_W-1:0] lo_q, hi_q, lo_n, hi_n;
   logic [M13_W-1:0]  c13;
   logic [M16_W-1:0]  c16;
   logic              wr_any;

   assign c13    = {hi_q, lo_q[PRE_W-1:0]} + M13_W'(1);
   assign c16    = {hi_q, lo_q} + M16_W'(1);
   assign wr_any = wr_lo_i | wr_hi_i;

   always_comb begin
      lo_n     = lo_q;
      hi_n     = hi_q;
      ovf_o    = 1'b0;
      hi_ovf_o = 1'b0;
      if (split_i) begin
         if (cnt_en_i && !wr_lo_i) begin
            lo_n  = lo_q + BYTE_W'(1);
            ovf_o = &lo_q;
         end
         if (hi_en_i && !wr_hi_i) begin
            hi_n     = hi_q + BYTE_W'(1);
            hi_ovf_o = &hi_q;
         end
      end else if (!hold_i && cnt_en_i && !wr_any) begin
         unique case (lay_i)
            LAY_13: begin
               hi_n               = c13[M13_W-1:PRE_W];
               lo_n[PRE_W-1:0]    = c13[PRE_W-1:0];
               ovf_o              = &{hi_q, lo_q[PRE_W-1:0]};
            end
            LAY_16: begin
               {hi_n, lo_n} = c16;
               ovf_o        = &{hi_q, lo_q};
            end
            LAY_RLD: begin
               if (&lo_q) begin
                  lo_n  = hi_q;
                  ovf_o = 1'b1;
               end else begin
                  lo_n = lo_q + BYTE_W'(1);
               end
            end
            default: begin
               lo_n = lo_q;
            end
         endcase
      end
      if (wr_lo_i) lo_n = wdata_i;
      if (wr_hi_i) hi_n = wdata_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_n;
         hi_q <= hi_n;
      end
   end

   assign lo_o = lo_q;
   assign hi_o = hi_q;

endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
   import dual_timer_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int PRE_W  = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic [1:0]        evt_pin_i,
   input  logic [1:0]        gate_pin_i,
   input  logic              wr_i,
   input  logic [REG_AW-1:0] addr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] rdata_o,
   output logic [1:0]        ovf_o
);

   localparam int NUNITS = 2;
   localparam int NIB_W  = 4;

   generate
      if (BYTE_W < 8) begin : g_bad_byte
         $error("dual_timer_unit: BYTE_W must be at least 8");
      end
      if (PRE_W < 1 || PRE_W >= BYTE_W) begin : g_bad_pre
         $error("dual_timer_unit: PRE_W must lie in 1..BYTE_W-1");
      end
   endgenerate

   logic [BYTE_W-1:0]             mode_q;
   logic [NUNITS-1:0]             run_q;
   logic [NUNITS-1:0]             flag_q;
   logic [NUNITS-1:0][BYTE_W-1:0] cnt_lo, cnt_hi;
   logic [NUNITS-1:0]             ovf_w, hovf_w, en_w;
   logic [NUNITS-1:0]             flag_set;
   logic                          split0;
   logic                          wr_mode, wr_ctrl;

   assign wr_mode = wr_i && (addr_i == RA_MODE);
   assign wr_ctrl = wr_i && (addr_i == RA_CTRL);
   assign split0  = (mode_q[1:0] == 2'(LAY_SPL));

   for (genvar g = 0; g < NUNITS; g++) begin : g_unit
      logic [NIB_W-1:0] nib;
      logic             fall;
      logic             wr_lo, wr_hi;

      assign nib   = mode_q[NIB_W*g +: NIB_W];
      assign wr_lo = wr_i && (addr_i == RA_U0LO + REG_AW'(2*g));
      assign wr_hi = wr_i && (addr_i == RA_U0HI + REG_AW'(2*g));

      dt_pin_edge u_edge (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .smp_i  (tick_i),
         .pin_i  (evt_pin_i[g]),
         .fall_o (fall)
      );

      assign en_w[g] = tick_i & run_q[g]
                     & (~nib[NIB_GATE] | gate_pin_i[g])
                     & (nib[NIB_EVT] ? fall : 1'b1);

      dt_count_core #(
         .BYTE_W (BYTE_W),
         .PRE_W  (PRE_W)
      ) u_core (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .lay_i    (tmr_layout_e'(nib[1:0])),
         .split_i  ((g == 0) ? split0 : 1'b0),
         .hold_i   ((g == 1) ? split0 : 1'b0),
         .cnt_en_i (en_w[g]),
         .hi_en_i  ((g == 0) ? (tick_i & run_q[1] & split0) : 1'b0),
         .wr_lo_i  (wr_lo),
         .wr_hi_i  (wr_hi),
         .wdata_i  (wdata_i),
         .lo_o     (cnt_lo[g]),
         .hi_o     (cnt_hi[g]),
         .ovf_o    (ovf_w[g]),
         .hi_ovf_o (hovf_w[g])
      );
   end

   assign flag_set[0] = ovf_w[0];
   assign flag_set[1] = ovf_w[1] | hovf_w[0] | hovf_w[1];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         mode_q <= '0;
         run_q  <= '0;
         flag_q <= '0;
      end else begin
         if (wr_mode) mode_q <= wdata_i;
         if (wr_ctrl) begin
            run_q  <= {wdata_i[CB_RUN1], wdata_i[CB_RUN0]};
            flag_q <= {wdata_i[CB_FLG1], wdata_i[CB_FLG0]} | flag_set;
         end else begin
            flag_q <= flag_q | flag_set;
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         RA_MODE: rdata_o = mode_q;
         RA_CTRL: begin
            rdata_o[CB_RUN0] = run_q[0];
            rdata_o[CB_FLG0] = flag_q[0];
            rdata_o[CB_RUN1] = run_q[1];
            rdata_o[CB_FLG1] = flag_q[1];
         end
         RA_U0LO: rdata_o = cnt_lo[0];
         RA_U0HI: rdata_o = cnt_hi[0];
         RA_U1LO: rdata_o = cnt_lo[1];
         RA_U1HI: rdata_o = cnt_hi[1];
         default: rdata_o = '0;
      endcase
   end

   assign ovf_o = flag_q;

endmodule

// File: rtl/dt_checker.sv
module dt_checker #(
   parameter int BYTE_W = 8
) (
   input logic                    clk_i,
   input logic                    rst_ni,
   input logic                    tick_i,
   input logic                    wr_i,
   input logic [1:0]              ovf_o,
   input logic [BYTE_W-1:0]       mode_q,
   input logic [1:0]              run_q,
   input logic [1:0][BYTE_W-1:0]  cnt_lo,
   input logic [1:0][BYTE_W-1:0]  cnt_hi
);

   // R10: flags are sticky without a control write
   a_r10_flag0_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_o[0] && !wr_i) |=> ovf_o[0]);
   a_r10_flag1_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_o[1] && !wr_i) |=> ovf_o[1]);

   // R3: no tick, no write -> counts frozen, flags not raised
   a_r3_idle_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !wr_i) |=> ($stable(cnt_lo) && $stable(cnt_hi)));
   a_r3_idle_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !wr_i && ovf_o == 2'b00) |=> (ovf_o == 2'b00));

   // R3: unit 0 stopped -> count held
   a_r3_stopped_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_q[0] && mode_q[1:0] != 2'd3 && !wr_i) |=>
         ($stable(cnt_lo[0]) && $stable(cnt_hi[0])));

   // R7: reload layout never alters the high byte
   a_r7_reload_hi_const: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q[1:0] == 2'd2 && !wr_i) |=> $stable(cnt_hi[0]));

   // R9: unit 1 frozen while unit 0 is split
   a_r9_unit1_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q[1:0] == 2'd3 && !wr_i) |=> ($stable(cnt_lo[1]) && $stable(cnt_hi[1])));

   // R8: unit 1 in its own layout 3 holds
   a_r8_unit1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q[5:4] == 2'd3 && !wr_i) |=> ($stable(cnt_lo[1]) && $stable(cnt_hi[1])));

endmodule

bind dual_timer_unit dt_checker #(.BYTE_W(BYTE_W)) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .tick_i (tick_i),
   .wr_i   (wr_i),
   .ovf_o  (ovf_o),
   .mode_q (mode_q),
   .run_q  (run_q),
   .cnt_lo (cnt_lo),
   .cnt_hi (cnt_hi)
);

// File: tb/dual_timer_unit_tb_top.sv
module dual_timer_unit_tb_top;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       tick_i = 1'b0;
   logic [1:0] evt_pin_i = 2'b00;
   logic [1:0] gate_pin_i = 2'b00;
   logic       wr_i = 1'b0;
   logic [2:0] addr_i = 3'd0;
   logic [7:0] wdata_i = 8'h00;
   logic [7:0] rdata_o;
   logic [1:0] ovf_o;

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;

   always #10 clk_i = ~clk_i;

   dual_timer_unit dut_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .evt_pin_i  (evt_pin_i),
      .gate_pin_i (gate_pin_i),
      .wr_i       (wr_i),
      .addr_i     (addr_i),
      .wdata_i    (wdata_i),
      .rdata_o    (rdata_o),
      .ovf_o      (ovf_o)
   );

   always @(posedge clk_i) begin
      cyc <= cyc + 1;
      if (cyc == 20000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: act=%0d cycles exp=<20000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk_i);
      wr_i = 1'b1; addr_i = a; wdata_i = d;
      @(negedge clk_i);
      wr_i = 1'b0;
   endtask

   task automatic ticks(input int n);
      @(negedge clk_i);
      tick_i = 1'b1;
      repeat (n) @(negedge clk_i);
      tick_i = 1'b0;
   endtask

   task automatic pin_step(input logic v);
      @(negedge clk_i);
      evt_pin_i[0] = v; tick_i = 1'b1;
      @(negedge clk_i);
      tick_i = 1'b0;
   endtask

   task automatic chk_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
      addr_i = a;
      #1;
      n_run = n_run + 1;
      if (rdata_o !== exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s reg%0d: act=%02h exp=%02h", req, a, rdata_o, exp);
      end
   endtask

   task automatic chk_flags(input string req, input logic [1:0] exp);
      n_run = n_run + 1;
      if (ovf_o !== exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s flags: act=%b exp=%b", req, ovf_o, exp);
      end
   endtask

   task automatic t_reset;
      for (int a = 0; a < 6; a++) chk_reg("R1", 3'(a), 8'h00);
      chk_flags("R1", 2'b00);
   endtask

   task automatic t_regmap;
      wr(3'd0, 8'hA5);
      chk_reg("R2", 3'd0, 8'hA5);
      wr(3'd1, 8'hFF);
      chk_reg("R2", 3'd1, 8'hF0);
      chk_flags("R10", 2'b11);
      wr(3'd1, 8'h00);
      chk_flags("R10", 2'b00);
      wr(3'd0, 8'h00);
   endtask

   task automatic t_mode16;
      wr(3'd1, 8'h00); wr(3'd0, 8'h01);
      wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
      wr(3'd1, 8'h10);
      chk_reg("R3", 3'd2, 8'hFE);
      ticks(1);
      chk_reg("R6", 3'd2, 8'hFF);
      chk_flags("R6", 2'b00);
      ticks(1);
      chk_reg("R6", 3'd2, 8'h00);
      chk_reg("R6", 3'd3, 8'h00);
      chk_flags("R6", 2'b01);
   endtask

   task automatic t_gate;
      wr(3'd1, 8'h00); wr(3'd0, 8'h09);
      wr(3'd2, 8'h00); wr(3'd3, 8'h00);
      wr(3'd1, 8'h10);
      ticks(5);
      chk_reg("R3", 3'd2, 8'h00);
      gate_pin_i[0] = 1'b1;
      ticks(5);
      chk_reg("R3", 3'd2, 8'h05);
      wr(3'd1, 8'h00);
      ticks(3);
      chk_reg("R3", 3'd2, 8'h05);
      gate_pin_i[0] = 1'b0;
   endtask

   task automatic t_mode13;
      wr(3'd1, 8'h00); wr(3'd0, 8'h00);
      wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
      wr(3'd1, 8'h10);
      ticks(1);
      chk_reg("R5", 3'd2, 8'hFF);
      chk_flags("R5", 2'b00);
      ticks(1);
      chk_reg("R5", 3'd2, 8'hE0);
      chk_reg("R5", 3'd3, 8'h00);
      chk_flags("R5", 2'b01);
      wr(3'd1, 8'h00);
      wr(3'd2, 8'h1F); wr(3'd3, 8'h00);
      wr(3'd1, 8'h10);
      ticks(1);
      chk_reg("R5", 3'd2, 8'h00);
      chk_reg("R5", 3'd3, 8'h01);
   endtask

   task automatic t_reload;
      wr(3'd1, 8'h00); wr(3'd0, 8'h02);
      wr(3'd2, 8'hFE); wr(3'd3, 8'h80);
      wr(3'd1, 8'h10);
      ticks(2);
      chk_reg("R7", 3'd2, 8'h80);
      chk_reg("R7", 3'd3, 8'h80);
      chk_flags("R7", 2'b01);
      ticks(1);
      chk_reg("R7", 3'd2, 8'h81);
   endtask

   task automatic t_event;
      wr(3'd1, 8'h00); wr(3'd0, 8'h05);
      wr(3'd2, 8'h00); wr(3'd3, 8'h00);
      wr(3'd1, 8'h10);
      pin_step(1'b1); pin_step(1'b0); pin_step(1'b0);
      pin_step(1'b1); pin_step(1'b0);
      chk_reg("R4", 3'd2, 8'h02);
      @(negedge clk_i); evt_pin_i[0] = 1'b1;
      @(negedge clk_i); evt_pin_i[0] = 1'b0;
      pin_step(1'b0);
      chk_reg("R4", 3'd2, 8'h02);
      pin_step(1'b1); pin_step(1'b0);
      chk_reg("R4", 3'd2, 8'h03);
   endtask

   task automatic t_u1_hold;
      wr(3'd1, 8'h00); wr(3'd0, 8'h30);
      wr(3'd4, 8'h10); wr(3'd5, 8'h00);
      wr(3'd1, 8'h40);
      ticks(4);
      chk_reg("R8", 3'd4, 8'h10);
      wr(3'd0, 8'h10);
      ticks(4);
      chk_reg("R8", 3'd4, 8'h14);
   endtask

   task automatic t_split;
      wr(3'd1, 8'h00); wr(3'd0, 8'h13);
      wr(3'd2, 8'hFE); wr(3'd3, 8'hFE);
      wr(3'd4, 8'h00); wr(3'd5, 8'h00);
      wr(3'd1, 8'h50);
      ticks(2);
      chk_reg("R9", 3'd2, 8'h00);
      chk_reg("R9", 3'd3, 8'h00);
      chk_flags("R9", 2'b11);
      chk_reg("R9", 3'd4, 8'h00);
      wr(3'd1, 8'h40);
      ticks(3);
      chk_reg("R9", 3'd2, 8'h00);
      chk_reg("R9", 3'd3, 8'h03);
      chk_flags("R9", 2'b00);
      chk_reg("R9", 3'd4, 8'h00);
      wr(3'd0, 8'h1B);
      wr(3'd1, 8'h50);
      ticks(2);
      chk_reg("R9", 3'd2, 8'h00);
      chk_reg("R9", 3'd3, 8'h05);
   endtask

   task automatic t_wr_prio;
      wr(3'd1, 8'h00); wr(3'd0, 8'h01);
      wr(3'd2, 8'h00); wr(3'd3, 8'h00);
      wr(3'd1, 8'h10);
      @(negedge clk_i);
      tick_i = 1'b1; wr_i = 1'b1; addr_i = 3'd2; wdata_i = 8'h55;
      @(negedge clk_i);
      tick_i = 1'b0; wr_i = 1'b0;
      chk_reg("R11", 3'd2, 8'h55);
      chk_reg("R11", 3'd3, 8'h00);
      ticks(1);
      chk_reg("R11", 3'd2, 8'h56);
      @(negedge clk_i);
      tick_i = 1'b1; wr_i = 1'b1; addr_i = 3'd3; wdata_i = 8'h22;
      @(negedge clk_i);
      tick_i = 1'b0; wr_i = 1'b0;
      chk_reg("R11", 3'd3, 8'h22);
      chk_reg("R11", 3'd2, 8'h56);
   endtask

   task automatic t_flag_prio;
      wr(3'd1, 8'h00); wr(3'd0, 8'h01);
      wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
      wr(3'd1, 8'h10);
      @(negedge clk_i);
      tick_i = 1'b1; wr_i = 1'b1; addr_i = 3'd1; wdata_i = 8'h10;
      @(negedge clk_i);
      tick_i = 1'b0; wr_i = 1'b0;
      chk_flags("R10", 2'b01);
      chk_reg("R10", 3'd2, 8'h00);
      ticks(3);
      chk_flags("R10", 2'b01);
      wr(3'd1, 8'h00);
      chk_flags("R10", 2'b00);
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i);
      t_reset();
      t_regmap();
      t_mode16();
      t_gate();
      t_mode13();
      t_reload();
      t_event();
      t_u1_hold();
      t_split();
      t_wr_prio();
      t_flag_prio();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule